// File: doc/BRIEF.md
# Dual-Compare Free-Running PWM Timer

The block is an up-counter that never clears early. It runs from a selectable prescaled clock and turns two compare values into a pulse-width-modulated output. When the counter reaches the "set" compare value, the output goes to its active level. When it reaches the "clear" compare value, the output goes back to its inactive level. The counter passes its maximum value, wraps to zero and carries on. The period is therefore always the full span of the counter multiplied by the prescale divisor, and the two compare values place the edges of the pulse inside that period.

Software-style configuration inputs control the timer:
- a 3-bit prescale code;
- two enables that must both be high for the timer to run;
- an output enable;
- a polarity bit;
- the two compare values.

The compare inputs act as shadow values. The timer copies them into its working compare registers only while it is stopped or at the instant the counter wraps. Changing them in the middle of a period therefore never produces a stray edge. A sticky overflow flag marks each wrap, and a one-cycle clear pulse resets it.

Top module: `dcpwm_timer`

## Requirements
- R1: While running, after k enabled clock cycles the count equals floor(k / 2^n) modulo 2^CNT_W, where n is the prescale code. After its maximum value the count wraps to 0 and keeps counting.
- R2: Prescale code n (0 to 7) divides the clock by 2^n. The first count step happens on the 2^n-th enabled cycle.
- R3: In the cycle after the count equals the set compare value, the output is at its active level.
- R4: In the cycle after the count equals the clear compare value, the output is at its inactive level. It stays there until the next set match.
- R5: When the two compare values are equal, the output stays at its inactive level at all times.
- R6: With act_high = 1 the active level is 1 and the inactive level is 0. With act_high = 0 both levels are inverted.
- R7: The timer runs only while both clk_sup_en and cnt_en are 1. One cycle after either enable is 0, the count is 0 and the output is at its inactive level.
- R8: While out_en is 0, pwm_o equals the inactive level (not act_high), whatever the count and compare values are.
- R9: ovf_flag becomes 1 on the clock where the count wraps from its maximum to 0. It holds until a cycle with ovf_clr = 1 clears it. A wrap in the same cycle as ovf_clr leaves the flag at 1.
- R10: Compare inputs take effect only while the timer is stopped or at a wrap. A change made mid-period first applies at count 0 of the next period.
- R11: After synchronous reset, count is 0, ovf_flag is 0 and pwm_o is at the inactive level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_sup_en | input | 1 | Clock-supply enable for the counter |
| cnt_en | input | 1 | Count enable; low stops and clears the timer |
| clk_sel | input | 3 | Prescale code n; the divisor is 2^n |
| out_en | input | 1 | Drives the pulse onto pwm_o when 1 |
| act_high | input | 1 | 1: active level is high; 0: active level is low |
| cmp_set | input | CNT_W | Shadow compare value that starts the pulse |
| cmp_clr | input | CNT_W | Shadow compare value that ends the pulse |
| ovf_clr | input | 1 | Write-one-to-clear pulse for ovf_flag |
| pwm_o | output | 1 | PWM output |
| ovf_flag | output | 1 | Sticky wrap indicator |
| count | output | CNT_W | Current counter value |

## Verification
The hardest case to reach from the ports is a clear pulse landing on the exact clock edge where the counter wraps. Only then does the priority of a set over a clear become visible. The bench starts the timer with the divide-by-one prescale, counts enabled cycles from a known start and raises ovf_clr on the cycle when the count shows its maximum value.

A second hard case is a shadow update made mid-period. The bench writes new compare values while the count sits between the old and new set values. It then checks that the old values govern the output until the wrap and the new ones govern it afterwards.

// File: rtl/pwm_tmr_pkg.sv
// Package: shared constants and helpers for the dual-compare PWM timer.
// Assumes: the prescale code is SEL_W bits wide, so the divisor reaches 2^(2^SEL_W - 1).
package pwm_tmr_pkg;

    localparam int SEL_W = 3;

    // Width of the prescale counter that the largest divisor needs.
    function automatic int presc_width(input int sel_w);
        return (1 << sel_w) - 1;
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
// Module: prescale tick generator.
// Produces a one-cycle tick every 2^sel clocks while run is high. It starts from
// zero each time run rises, so the first tick comes on the 2^sel-th enabled cycle.
// Assumes: sel is held stable while running.
module pwm_prescaler
    import pwm_tmr_pkg::*;
#(
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [SW-1:0] sel,
    output logic          tick
);
    localparam int PRE_W = presc_width(SW);

    logic [PRE_W-1:0] presc_q;
    logic [PRE_W-1:0] mask;

    // One mask bit per divider stage: stage i takes part when the code exceeds i.
    for (genvar i = 0; i < PRE_W; i++) begin : g_mask
        assign mask[i] = (int'(sel) > i);
    end

    // Free-running divider, held at zero while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            presc_q <= '0;
        end else begin
            presc_q <= presc_q + PRE_W'(1);
        end
    end

    // Tick when all selected low bits of the divider are ones.
    assign tick = run && ((presc_q & mask) == mask);

endmodule

// File: rtl/pwm_counter.sv
// Module: free-running up-counter.
// Advances by one on each tick, wraps from all-ones to zero and never clears on a
// compare match. It is forced to zero while stopped.
// Assumes: tick is a single-cycle pulse qualified by run.
module pwm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt_q;

    // Count register: zero when stopped, increments on tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign count = cnt_q;
    assign wrap  = tick && (cnt_q == '1);

endmodule

// File: rtl/pwm_compare.sv
// Module: compare registers and output state.
// Holds working copies of the set and clear values, loaded from the shadow inputs
// while stopped or on a wrap. Tracks whether the pulse is active by comparing them
// with the current count every clock.
// Assumes: count and wrap come from pwm_counter in the same clock domain.
module pwm_compare #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             wrap,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] set_shadow,
    input  logic [CNT_W-1:0] clr_shadow,
    output logic             active
);
    logic [CNT_W-1:0] set_q;
    logic [CNT_W-1:0] clr_q;
    logic             act_q;

    // Working compare values: follow the shadows while stopped, latch them at each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_q <= '0;
            clr_q <= '0;
        end else if (!run || wrap) begin
            set_q <= set_shadow;
            clr_q <= clr_shadow;
        end
    end

    // Pulse state: equal values hold it off; a set match turns it on, a clear match off.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            act_q <= 1'b0;
        end else if (set_q == clr_q) begin
            act_q <= 1'b0;
        end else if (count == set_q) begin
            act_q <= 1'b1;
        end else if (count == clr_q) begin
            act_q <= 1'b0;
        end
    end

    assign active = act_q;

endmodule

// File: rtl/dcpwm_timer.sv
// Module: top of the dual-compare free-running PWM timer.
// Combines the prescaler, the counter and the compare stage. Keeps the sticky
// overflow flag and maps the pulse state onto the pin through polarity and output enable.
// Assumes: all inputs are synchronous to clk; ovf_clr is a one-cycle pulse.
module dcpwm_timer
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_sup_en,
    input  logic             cnt_en,
    input  logic [SEL_W-1:0] clk_sel,
    input  logic             out_en,
    input  logic             act_high,
    input  logic [CNT_W-1:0] cmp_set,
    input  logic [CNT_W-1:0] cmp_clr,
    input  logic             ovf_clr,
    output logic             pwm_o,
    output logic             ovf_flag,
    output logic [CNT_W-1:0] count
);
    logic run;
    logic tick;
    logic wrap;
    logic active;
    logic ovf_q;

    assign run = clk_sup_en && cnt_en;

    pwm_prescaler #(.SW(SEL_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .sel   (clk_sel),
        .tick  (tick)
    );

    pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick),
        .count (count),
        .wrap  (wrap)
    );

    pwm_compare #(.CNT_W(CNT_W)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .wrap       (wrap),
        .count      (count),
        .set_shadow (cmp_set),
        .clr_shadow (cmp_clr),
        .active     (active)
    );

    // Sticky overflow flag: a wrap sets it and wins over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (wrap) begin
            ovf_q <= 1'b1;
        end else if (ovf_clr) begin
            ovf_q <= 1'b0;
        end
    end

    assign ovf_flag = ovf_q;
    assign pwm_o    = (out_en && active) ? act_high : !act_high;

endmodule

// File: rtl/dcpwm_timer_chk.sv
// Module: assertion checker for dcpwm_timer, attached by bind below.
// Assumes: the same CNT_W as the bound instance.
module dcpwm_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clk_sup_en,
    input logic             cnt_en,
    input logic             act_high,
    input logic             ovf_clr,
    input logic             pwm_o,
    input logic             ovf_flag,
    input logic [CNT_W-1:0] count
);
    logic run;
    assign run = clk_sup_en && cnt_en;

    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (count == '0));

    assert_idle_inactive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pwm_o == !act_high));

    assert_single_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (count == $past(count) || count == $past(count) + CNT_W'(1)));

    assert_flag_on_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> (count == '0 && $past(count) == '1));

    assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_clr |=> (!ovf_flag || count == '0));

endmodule

bind dcpwm_timer dcpwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_sup_en (clk_sup_en),
    .cnt_en     (cnt_en),
    .act_high   (act_high),
    .ovf_clr    (ovf_clr),
    .pwm_o      (pwm_o),
    .ovf_flag   (ovf_flag),
    .count      (count)
);

// File: tb/sim_dcpwm_timer.sv
module sim_dcpwm_timer;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 4;
    localparam int SPAN       = 1 << W;
    localparam int WD_LIMIT   = 150000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clk_sup_en = 1'b0;
    logic         cnt_en = 1'b0;
    logic [2:0]   clk_sel = '0;
    logic         out_en = 1'b0;
    logic         act_high = 1'b1;
    logic [W-1:0] cmp_set = '0;
    logic [W-1:0] cmp_clr = '0;
    logic         ovf_clr = 1'b0;
    logic         pwm_o;
    logic         ovf_flag;
    logic [W-1:0] count;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    dcpwm_timer #(.CNT_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .clk_sup_en(clk_sup_en), .cnt_en(cnt_en),
        .clk_sel(clk_sel), .out_en(out_en), .act_high(act_high),
        .cmp_set(cmp_set), .cmp_clr(cmp_clr), .ovf_clr(ovf_clr),
        .pwm_o(pwm_o), .ovf_flag(ovf_flag), .count(count)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual cycles %0d expected below %0d", cyc, WD_LIMIT);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Expected pulse state after k enabled cycles, from the compare values and prescale.
    function automatic bit exp_act(input int s, input int c, input int k, input int sel);
        int m, v;
        bit s_hit, c_hit;
        if (k == 0 || s == c) return 1'b0;
        m = (k - 1) >> sel;
        v = m % SPAN;
        s_hit = (s <= v);
        c_hit = (c <= v);
        if (s_hit && c_hit) return (s > c);
        if (s_hit) return 1'b1;
        if (c_hit) return 1'b0;
        return (m >= SPAN) ? (s > c) : 1'b0;
    endfunction

    function automatic bit pin_lvl(input bit act, input bit pol, input bit oe);
        return (oe && act) ? pol : !pol;
    endfunction

    // Load the configuration while stopped and clear the flag, then start at a falling edge.
    task automatic start(input int sel, input int s, input int c, input bit pol, input bit oe);
        cnt_en     = 1'b0;
        clk_sup_en = 1'b1;
        clk_sel    = 3'(sel);
        cmp_set    = W'(s);
        cmp_clr    = W'(c);
        act_high   = pol;
        out_en     = oe;
        ovf_clr    = 1'b1;
        @(negedge clk);
        ovf_clr    = 1'b0;
        cnt_en     = 1'b1;
    endtask

    task automatic stop_and_check(input bit pol);
        cnt_en = 1'b0;
        @(negedge clk);
        chk(count == '0, "R7 count after stop", int'(count), 0);
        chk(pwm_o == !pol, "R7 pin after stop", int'(pwm_o), int'(!pol));
    endtask

    task automatic run_case(input int sel, input int s, input int c, input bit pol,
                            input bit oe, input int n);
        bit e;
        start(sel, s, c, pol, oe);
        for (int k = 0; k <= n; k++) begin
            if (k > 0) @(negedge clk);
            chk(int'(count) == ((k >> sel) % SPAN), "R1/R2 count", int'(count), (k >> sel) % SPAN);
            chk(ovf_flag == (k >= (SPAN << sel)), "R9 flag", int'(ovf_flag), int'(k >= (SPAN << sel)));
            e = pin_lvl(exp_act(s, c, k, sel), pol, oe);
            if (!oe)
                chk(pwm_o == e, "R8 pin with output disabled", int'(pwm_o), int'(e));
            else if (s == c)
                chk(pwm_o == e, "R5 equal compares", int'(pwm_o), int'(e));
            else
                chk(pwm_o == e, "R3/R4/R6 pin", int'(pwm_o), int'(e));
        end
        stop_and_check(pol);
    endtask

    initial begin
        bit e;
        // R11: reset state.
        repeat (3) @(negedge clk);
        chk(count == '0, "R11 count in reset", int'(count), 0);
        chk(ovf_flag == 1'b0, "R11 flag in reset", int'(ovf_flag), 0);
        chk(pwm_o == 1'b0, "R11 pin in reset", int'(pwm_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(count == '0 && !ovf_flag, "R11 after release", int'(count), 0);

        // R7: count enable high but clock supply off.
        clk_sup_en = 1'b0;
        cnt_en     = 1'b1;
        cmp_set    = W'(0);
        cmp_clr    = W'(8);
        out_en     = 1'b1;
        act_high   = 1'b1;
        repeat (10) @(negedge clk);
        chk(count == '0, "R7 no supply count", int'(count), 0);
        chk(pwm_o == 1'b0, "R7 no supply pin", int'(pwm_o), 0);
        cnt_en = 1'b0;
        @(negedge clk);

        // Exhaustive compare pairs at divide-by-one, polarity alternating.
        for (int s = 0; s < SPAN; s++)
            for (int c = 0; c < SPAN; c++)
                run_case(0, s, c, bit'((s ^ c) & 1), 1'b1, 2 * SPAN + 4);

        // Every prescale code with a few pairs.
        for (int sel = 1; sel < 8; sel++) begin
            run_case(sel, 3, 10, 1'b1, 1'b1, (2 * SPAN << sel) + 4);
            run_case(sel, 12, 2, 1'b0, 1'b1, (2 * SPAN << sel) + 4);
            run_case(sel, 7, 7, 1'b1, 1'b1, (SPAN << sel) + 4);
        end

        // R8: output disabled, both polarities.
        run_case(0, 2, 9, 1'b1, 1'b0, 2 * SPAN + 4);
        run_case(0, 2, 9, 1'b0, 1'b0, 2 * SPAN + 4);

        // R10: shadow change mid-period applies only after the wrap.
        start(0, 3, 10, 1'b1, 1'b1);
        for (int k = 1; k <= 3 * SPAN; k++) begin
            @(negedge clk);
            if (k == 5) begin
                cmp_set = W'(5);
                cmp_clr = W'(12);
            end
            e = (k <= SPAN) ? exp_act(3, 10, k, 0) : exp_act(5, 12, k, 0);
            chk(pwm_o == e, "R10 shadow timing", int'(pwm_o), int'(e));
        end
        stop_and_check(1'b1);

        // R9: clear on the wrap edge loses; a later clear wins.
        start(0, 1, 2, 1'b1, 1'b1);
        repeat (SPAN - 1) @(negedge clk);
        chk(int'(count) == SPAN - 1 && !ovf_flag, "R9 before wrap", int'(ovf_flag), 0);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        chk(ovf_flag == 1'b1, "R9 set beats clear", int'(ovf_flag), 1);
        @(negedge clk);
        chk(ovf_flag == 1'b1, "R9 sticky", int'(ovf_flag), 1);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        chk(ovf_flag == 1'b0, "R9 cleared", int'(ovf_flag), 0);
        stop_and_check(1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule